// File: doc/BRIEF.md
# Synchronous SRAM Cycle Controller

This block sequences the control side of a pipelined synchronous SRAM. On every rising clock edge it samples an active-low clock enable, an active-low chip enable, an active-low write enable, active-low byte-write selects, an advance/load input and a sleep request. From these it decides what kind of cycle the edge is: a read, a write, a burst beat, a stall, a deselect, a no-op or power-down. It reports that decision on `cyc_kind` and gates an internal clock qualifier `clk_act`. It drives the read-data enable that stands in for the tri-state control, and it raises per-byte write strobes.

Reads and writes pass through a two-stage pipeline. Read data appears two enabled edges after the command. Write data is taken from `wdata` at the second enabled edge after the command. A stall freezes everything, so it lengthens both latencies. Burst beats reuse the upper address bits of the last loaded address and compute the two low bits from a beat counter, in either linear or interleaved order.

The sleep request passes through a two-flop synchroniser before it powers the block down. While powered down, the pipeline is discarded. For a short window after wake-up, write commands are refused and only reads or deselects take effect. A small register file stands in for the storage array so that data paths can be checked.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, `rdata_oe` is 0, `wr_be` is 0 and `pwr_down` is 0. A burst-continue command issued before any read or write is classed as a deselect (`cyc_kind` 0).
- R2: `cyc_kind` is combinational and uses this encoding: 0 deselect, 1 read, 2 write, 3 burst read, 4 burst write, 5 stall, 6 no-op, 7 power-down. The priority order, highest first, is: power-down, stall (`clk_en_n`=1), burst continue (`adv`=1), deselect (`ce_n`=1), read (`we_n`=1), then write or no-op.
- R3: A read or burst-read command at an enabled edge makes `rdata_oe` 1 with the addressed word on `rdata` after the second following enabled edge.
- R4: For a write command, `wdata` is sampled at the second following enabled edge. During that cycle `wr_be[i]` is 1 exactly for each byte i whose `bw_n[i]` was 0 at the command. Byte i occupies bits [8i+7:8i], and only those bytes of the word change.
- R5: When `clk_en_n` is 1, no state advances and all command and address inputs are ignored. `rdata` and `rdata_oe` hold their values: still driving after a read, still off after a write. Each stall cycle adds one cycle to read and write latency.
- R6: A deselect cycle turns `rdata_oe` off once it reaches the output stage. A burst-continue command that follows a deselect is again a deselect, whatever `ce_n` and `we_n` are.
- R7: With `adv`=1 after a read (or write), the cycle is a burst read (or burst write), and `ce_n` and `we_n` are ignored. The address keeps the upper bits of the last loaded address.
- R8: The low two bits of burst beat n (n = 0 for the loaded address, then 1, 2, 3) are (start+n) mod 4 when `burst_ilv`=0 and start XOR n when `burst_ilv`=1.
- R9: A write command with every `bw_n` bit at 1 is a no-op (`cyc_kind` 6). It samples no address, leaves the burst position unchanged so that a later burst-continue resumes the interrupted sequence, and puts a bubble in the pipeline.
- R10: `pwr_down` rises after the second rising edge at which `sleep` is sampled high. While it is 1, `rdata_oe`, `wr_be` and `clk_act` are 0, commands are ignored, and operations in flight are discarded.
- R11: For the two cycles after `pwr_down` falls, a write command is turned into a no-op (`cyc_kind` 6), while reads and deselects act normally.
- R12: `clk_act` is 1 exactly when `clk_en_n` is 0 and `pwr_down` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 means stall |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| bw_n | input | NB | Active-low byte-write selects |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Asynchronous power-down request |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, sampled two enabled edges after the command |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | Read-data drive enable; 0 stands for high impedance |
| wr_be | output | NB | Per-byte write strobes for the current cycle |
| clk_act | output | 1 | Internal clock qualifier |
| pwr_down | output | 1 | Powered-down indication |
| cyc_kind | output | 3 | Decoded cycle kind |

## Verification
The bench first fills every word with a distinct pattern derived from its address. It then runs bursts from each of the four start offsets in both linear and interleaved order. Each beat's expected address comes from the bench's own arithmetic, so the bursts separate the two orders and show any wrong wrap of the counter. A second set of sequences inserts stalls carrying garbage write commands, partial byte writes, deselects followed by burst-continue, and a no-op in the middle of a burst. These reveal whether stalls really freeze state, whether byte lanes are kept apart, and whether a no-op leaves the burst position intact. A sleep sequence puts a read in flight at entry, then issues writes and reads inside the wake-up window. This tells discarded work and refused writes apart from normal operation.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    CK_DESEL = 3'd0,
    CK_READ  = 3'd1,
    CK_WRITE = 3'd2,
    CK_BRD   = 3'd3,
    CK_BWR   = 3'd4,
    CK_STALL = 3'd5,
    CK_NOP   = 3'd6,
    CK_PDN   = 3'd7
  } cyc_kind_e;

  typedef enum logic [1:0] {
    LO_NONE = 2'd0,
    LO_RD   = 2'd1,
    LO_WR   = 2'd2
  } last_op_e;

  // low address bits of a burst beat: linear adds, interleaved XORs
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
    burst_lo = ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/sram_cyc_sleep.sv
module sram_cyc_sleep #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic pwr_down_o,
  output logic wake_blk_o
);
  localparam int WCW = $clog2(WAKE_CYC + 1);

  logic           sync1_q;
  logic           sync2_q;
  logic [WCW-1:0] wake_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= 1'b0;
      sync2_q    <= 1'b0;
      wake_cnt_q <= '0;
    end else begin
      sync1_q <= sleep_i;
      sync2_q <= sync1_q;
      if (sync2_q)
        wake_cnt_q <= WCW'(WAKE_CYC);
      else if (wake_cnt_q != '0)
        wake_cnt_q <= wake_cnt_q - 1'b1;
    end
  end

  assign pwr_down_o = sync2_q;
  assign wake_blk_o = !sync2_q && (wake_cnt_q != '0);

endmodule

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
  import sram_cyc_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down,
  input  logic          wake_blk,
  input  logic          clk_en_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic          adv,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output cyc_kind_e     kind,
  output logic          issue_rd,
  output logic          issue_wr,
  output logic [AW-1:0] issue_addr,
  output logic [NB-1:0] issue_be
);
  last_op_e      last_q;
  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  logic [AW-1:0] burst_addr;
  logic          is_load;

  always_comb begin
    burst_addr      = base_q;
    burst_addr[1:0] = burst_lo(base_q[1:0], step_q, ilv);
  end

  always_comb begin
    if (pwr_down)
      kind = CK_PDN;
    else if (clk_en_n)
      kind = CK_STALL;
    else if (adv) begin
      case (last_q)
        LO_RD:   kind = CK_BRD;
        LO_WR:   kind = CK_BWR;
        default: kind = CK_DESEL;
      endcase
    end else if (ce_n)
      kind = CK_DESEL;
    else if (we_n)
      kind = CK_READ;
    else if (wake_blk || (&bw_n))
      kind = CK_NOP;
    else
      kind = CK_WRITE;
  end

  assign is_load    = (kind == CK_READ) || (kind == CK_WRITE);
  assign issue_rd   = (kind == CK_READ) || (kind == CK_BRD);
  assign issue_wr   = (kind == CK_WRITE) || (kind == CK_BWR);
  assign issue_addr = is_load ? addr : burst_addr;
  assign issue_be   = ~bw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LO_NONE;
      base_q <= '0;
      step_q <= 2'd0;
    end else begin
      case (kind)
        CK_READ: begin
          base_q <= addr;
          step_q <= 2'd1;
          last_q <= LO_RD;
        end
        CK_WRITE: begin
          base_q <= addr;
          step_q <= 2'd1;
          last_q <= LO_WR;
        end
        CK_BRD, CK_BWR: step_q <= step_q + 2'd1;
        CK_DESEL, CK_PDN: last_q <= LO_NONE;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sram_cyc_pipe.sv
module sram_cyc_pipe #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down,
  input  logic          clk_act,
  input  logic          in_rd,
  input  logic          in_wr,
  input  logic [AW-1:0] in_addr,
  input  logic [NB-1:0] in_be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q,
  output logic          oe_q,
  output logic [NB-1:0] wr_be
);
  localparam int BW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic          s1_rd, s1_wr, s2_rd, s2_wr;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NB-1:0] s1_be, s2_be;
  logic [DW-1:0] mem [DEPTH];

  assign wr_be = (s2_wr && clk_act) ? s2_be : '0;

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (wr_be[b]) mem[s2_addr][b*BW +: BW] <= wdata[b*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_be <= '0;
      s2_rd <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_be <= '0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else if (pwr_down) begin
      s1_rd <= 1'b0; s1_wr <= 1'b0;
      s2_rd <= 1'b0; s2_wr <= 1'b0;
      oe_q  <= 1'b0;
    end else if (clk_act) begin
      s1_rd   <= in_rd;
      s1_wr   <= in_wr;
      s1_addr <= in_addr;
      s1_be   <= in_be;
      s2_rd   <= s1_rd;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      if (s2_rd) begin
        rdata_q <= mem[s2_addr];
        oe_q    <= 1'b1;
      end else begin
        oe_q    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int NB       = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic          adv,
  input  logic          burst_ilv,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic [NB-1:0] wr_be,
  output logic          clk_act,
  output logic          pwr_down,
  output logic [2:0]    cyc_kind
);
  logic          wake_blk;
  cyc_kind_e     kind;
  logic          issue_rd, issue_wr;
  logic [AW-1:0] issue_addr;
  logic [NB-1:0] issue_be;
  logic          oe_q;

  sram_cyc_sleep #(.WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep),
    .pwr_down_o(pwr_down),
    .wake_blk_o(wake_blk)
  );

  sram_cyc_decode #(.AW(AW), .NB(NB)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .wake_blk  (wake_blk),
    .clk_en_n  (clk_en_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .bw_n      (bw_n),
    .adv       (adv),
    .ilv       (burst_ilv),
    .addr      (addr),
    .kind      (kind),
    .issue_rd  (issue_rd),
    .issue_wr  (issue_wr),
    .issue_addr(issue_addr),
    .issue_be  (issue_be)
  );

  assign clk_act = !clk_en_n && !pwr_down;

  sram_cyc_pipe #(.AW(AW), .DW(DW), .NB(NB)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_down(pwr_down),
    .clk_act (clk_act),
    .in_rd   (issue_rd),
    .in_wr   (issue_wr),
    .in_addr (issue_addr),
    .in_be   (issue_be),
    .wdata   (wdata),
    .rdata_q (rdata),
    .oe_q    (oe_q),
    .wr_be   (wr_be)
  );

  assign rdata_oe = oe_q && !pwr_down;
  assign cyc_kind = kind;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int DW = 16,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          adv,
  input logic          sleep,
  input logic          pwr_down,
  input logic          wake_blk,
  input logic          clk_act,
  input logic [2:0]    cyc_kind,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic [NB-1:0] wr_be
);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !pwr_down) |=> (pwr_down || ($stable(rdata) && $stable(rdata_oe))));

  a_r12_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_act |-> (wr_be == '0));

  a_r10_entry_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(sleep, 2));

  a_r10_quiet_down: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!rdata_oe && (wr_be == '0) && (cyc_kind == 3'd7)));

  a_r11_wake_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wake_blk |-> (cyc_kind != 3'd2));

  a_r6_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_kind == 3'd0) && !pwr_down) ##1 (adv && !clk_en_n && !pwr_down)
      |-> (cyc_kind == 3'd0));

  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (((cyc_kind == 3'd1) || (cyc_kind == 3'd3)) && clk_act) ##1 clk_act ##1 clk_act
      |=> (rdata_oe || pwr_down));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.DW(DW), .NB(NB)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_en_n(clk_en_n),
  .adv     (adv),
  .sleep   (sleep),
  .pwr_down(pwr_down),
  .wake_blk(wake_blk),
  .clk_act (clk_act),
  .cyc_kind(cyc_kind),
  .rdata   (rdata),
  .rdata_oe(rdata_oe),
  .wr_be   (wr_be)
);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en_n, ce_n, we_n, adv, burst_ilv, sleep;
  logic [1:0]  bw_n;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rdata_oe, clk_act, pwr_down;
  logic [1:0]  wr_be;
  logic [2:0]  cyc_kind;

  int total = 0;
  int bad = 0;
  int window_ops = 0;
  bit done = 0;
  logic [15:0] mem_m [16];

  always #5 clk = ~clk;

  sram_cycle_ctrl i_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce_n(ce_n), .we_n(we_n),
    .bw_n(bw_n), .adv(adv), .burst_ilv(burst_ilv), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .wr_be(wr_be),
    .clk_act(clk_act), .pwr_down(pwr_down), .cyc_kind(cyc_kind)
  );

  function automatic logic [15:0] pat(input logic [3:0] a);
    pat = {a, ~a, a ^ 4'h5, a + 4'h3};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cen, input logic ce, input logic we, input logic [1:0] bw,
                       input logic ad, input logic [3:0] a, input logic [15:0] wd);
    clk_en_n = cen; ce_n = ce; we_n = we; bw_n = bw; adv = ad; addr = a; wdata = wd;
    if (sleep && !pwr_down && !cen && (ad || !ce)) begin
      window_ops++;
      $display("note: command issued inside the sleep-entry window, result not guaranteed");
    end
  endtask

  task automatic desel(input logic [15:0] wd);
    drive(1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 4'h0, wd);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] rb [3];
    rst_n = 1'b0; sleep = 1'b0; burst_ilv = 1'b0;
    desel(16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 oe", rdata_oe, 0);
    chk("R1 wr_be", wr_be, 0);
    chk("R1 pwr_down", pwr_down, 0);
    drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'h0, 16'h0);
    #1 chk("R1 burst after reset", cyc_kind, 0);
    chk("R12 clk_act", clk_act, 1);

    // fill memory; write data two enabled edges after each command (R4)
    for (int t = 0; t < 18; t++) begin
      if (t < 16) drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'(t), t >= 2 ? pat(4'(t - 2)) : 16'h0);
      else desel(pat(4'(t - 2)));
      #1 if (t == 5) chk("R4 full strobes", wr_be, 2'b11);
      if (t == 3) chk("R2 write kind", cyc_kind, 2);
      tick;
    end
    for (int i = 0; i < 16; i++) mem_m[i] = pat(4'(i));

    // burst sweep over start offsets and both orders (R3 R7 R8)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [1:0] hi;
        hi = 2'(s + m);
        burst_ilv = m[0];
        for (int n = 0; n < 7; n++) begin
          if (n == 0) drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, {hi, 2'(s)}, 16'h0);
          else if (n <= 3) drive(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 4'hF, 16'h0);
          else desel(16'h0);
          #1 if (n >= 1 && n <= 3) chk("R7 burst read kind", cyc_kind, 3);
          tick;
          if (n >= 2 && n <= 5) begin
            logic [1:0] lo;
            lo = m[0] ? (2'(s) ^ 2'(n - 2)) : 2'(s + n - 2);
            chk("R8 beat data", rdata, mem_m[{hi, lo}]);
            chk("R3 oe on", rdata_oe, 1);
          end
          if (n == 6) chk("R6 oe off after deselect", rdata_oe, 0);
        end
      end
    end
    burst_ilv = 1'b0;

    // stall lengthens read latency and ignores inputs (R5 R12 R2)
    drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 4'h3, 16'h0); tick;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 4'h9, 16'hDEAD);
    #1 chk("R12 stall clk_act", clk_act, 0);
    chk("R2 stall kind", cyc_kind, 5);
    tick; chk("R5 latency 1", rdata_oe, 0);
    tick; chk("R5 latency 2", rdata_oe, 0);
    desel(16'h0); tick; chk("R5 latency 3", rdata_oe, 0);
    desel(16'h0); tick;
    chk("R5 delayed data", rdata, mem_m[3]);
    chk("R5 delayed oe", rdata_oe, 1);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 4'h9, 16'hBEEF);
    tick; chk("R5 hold data", rdata, mem_m[3]); chk("R5 hold oe", rdata_oe, 1);
    tick; chk("R5 hold data 2", rdata, mem_m[3]);

    // write with stall inside, then partial write (R4 R5)
    drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'h6, 16'h0); tick;
    drive(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'h0, 16'h1111); tick;
    desel(16'h2222); tick;
    desel(16'h5A3C);
    #1 chk("R4 strobes with stall", wr_be, 2'b11);
    tick; chk("R5 off after write", rdata_oe, 0);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'h0, 16'h0);
    tick; chk("R5 stays off after write", rdata_oe, 0);
    mem_m[6] = 16'h5A3C;
    drive(1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 4'hA, 16'h0); tick;
    desel(16'h0); tick;
    desel(16'h77EE);
    #1 chk("R4 byte0 strobe", wr_be, 2'b01);
    tick;
    mem_m[10] = {mem_m[10][15:8], 8'hEE};

    // read back written words and the word a stall tried to write (R4 R5)
    rb[0] = 4'h6; rb[1] = 4'hA; rb[2] = 4'h9;
    for (int n = 0; n < 5; n++) begin
      if (n < 3) drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, rb[n], 16'h0);
      else desel(16'h0);
      tick;
      if (n >= 2) chk(n == 4 ? "R5 stall write ignored" : "R4 readback", rdata, mem_m[rb[n - 2]]);
    end

    // deselect hold (R6)
    desel(16'h0); tick;
    drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'h1, 16'h0);
    #1 chk("R6 burst after deselect", cyc_kind, 0);
    tick; desel(16'h0); tick;
    chk("R6 oe off", rdata_oe, 0);

    // no-op in the middle of a linear burst (R9)
    for (int n = 0; n < 7; n++) begin
      if (n == 0) drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 4'h5, 16'h0);
      else if (n == 1 || n == 3) drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'h0, 16'h0);
      else if (n == 2) drive(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 4'hC, 16'h0);
      else desel(16'h0);
      #1 if (n == 2) chk("R9 no-op kind", cyc_kind, 6);
      if (n == 4) chk("R9 no strobe", wr_be, 0);
      tick;
      if (n == 2) chk("R9 beat0", rdata, mem_m[5]);
      if (n == 3) chk("R9 beat1", rdata, mem_m[6]);
      if (n == 4) chk("R9 bubble", rdata_oe, 0);
      if (n == 5) chk("R9 resumed beat2", rdata, mem_m[7]);
    end

    // sleep entry with a read in flight, then wake window (R10 R11 R2)
    sleep = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 4'h2, 16'h0);
    tick; chk("R10 not yet down", pwr_down, 0);
    desel(16'h0); tick;
    chk("R10 down after two edges", pwr_down, 1);
    chk("R10 oe off", rdata_oe, 0);
    drive(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 4'h2, 16'h0);
    #1 chk("R2 power-down over stall", cyc_kind, 7);
    drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'h8, 16'h0);
    #1 chk("R10 no strobe", wr_be, 0);
    chk("R12 down clk_act", clk_act, 0);
    for (int k = 0; k < 3; k++) begin
      tick; chk("R10 stays quiet", rdata_oe, 0);
    end
    sleep = 1'b0;
    desel(16'h0); tick; chk("R10 still down", pwr_down, 1);
    desel(16'h0); tick; chk("R10 awake", pwr_down, 0);
    chk("R10 in-flight read discarded", rdata_oe, 0);
    drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'h8, 16'h0);
    #1 chk("R11 write refused", cyc_kind, 6);
    tick; chk("R10 no late data", rdata_oe, 0);
    drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 4'hB, 16'h0);
    #1 chk("R11 read allowed", cyc_kind, 1);
    tick;
    drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'h8, 16'h0);
    #1 chk("R11 write after window", cyc_kind, 2);
    desel(16'h0); tick;
    desel(16'h0); tick;
    chk("R11 wake read data", rdata, mem_m[11]);
    chk("R11 wake read oe", rdata_oe, 1);
    drive(1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 4'h8, 16'h0); tick;
    desel(16'h0); tick;
    desel(16'h0); tick;
    chk("R11 refused write left word", rdata, mem_m[8]);

    $display("entry-window commands flagged: %0d", window_ops);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule